// File: doc/BRIEF.md
# Vertical Field Timing Generator

This block produces the vertical timing that accompanies an 8-bit digital video port sampled at 27 MHz. It counts pixel cycles within a line and lines within a frame. From these counts it drives an active-low vertical sync, a field flag, and a line enable. The line enable tells the downstream capture path on which lines pixel data is expected. Two timing families are supported. The first is a 525-line interlaced frame of 858-cycle lines. The second is a 625-line progressive frame of 864-cycle lines, whose sync pulse ends halfway through a line.

The mode input is sampled at reset and at each frame boundary, so the counters never mix line lengths within one frame. Each frame holds two fields of unequal length. In progressive mode the second field starts exactly 312 lines after the first, and its sync pulse runs 2.5 lines. In interlaced mode each field's pulse covers three whole lines. In that mode the frame starts at line 4, so the second field starts at line 266 and the line counter wraps from 525 to 1 inside the second field.

Top module: `field_timing_gen`

## Requirements
- R1: While rst is high at a clock edge, the outputs become: pixelCnt 0, fieldOut 0, vsyncN 0 and activeLine 0. lineNum becomes 1 if modeSel is 1 (progressive) or 4 if modeSel is 0 (interlaced).
- R2: pixelCnt counts 0 up to the line length minus one and then returns to 0. The line length is 864 in progressive mode and 858 in interlaced mode. lineNum changes only on the edge where pixelCnt returns to 0.
- R3: In progressive mode lineNum runs from 1 to 625 and then returns to 1. In interlaced mode it runs from 4 to 525, wraps to 1, and continues to 3 before the frame restarts at line 4.
- R4: In progressive mode vsyncN goes low at pixel 0 of line 1 and at pixel 0 of line 313. Each time it stays low for 2160 cycles, so it rises at pixel 432 of line 3 or of line 315.
- R5: In interlaced mode vsyncN goes low at pixel 0 of line 4 and at pixel 0 of line 266. Each time it stays low for three whole lines, so it rises at pixel 0 of line 7 or of line 269.
- R6: fieldOut is 0 during the first field and 1 during the second field. It changes on the same edge where vsyncN falls. The first field is 312 lines in progressive mode and 262 lines in interlaced mode. The second field is 313 lines in progressive mode and 263 lines in interlaced mode.
- R7: In progressive mode activeLine is 1 exactly on lines 23 to 309 and on lines 335 to 622.
- R8: In interlaced mode activeLine is 1 exactly on lines 22 to 261 and on lines 284 to 522.
- R9: A change on modeSel in the middle of a frame has no effect until the current frame ends. The next frame then starts at pixel 0 of the new mode's first line, with the new line length and the new sync length.
- R10: activeLine changes only on the edge that starts a line, when pixelCnt becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | Timing family request: 1 progressive 625-line, 0 interlaced 525-line |
| vsyncN | output | 1 | Vertical sync, active low |
| fieldOut | output | 1 | 0 in the first field, 1 in the second field |
| lineNum | output | LW (10 by default) | Current line number, counted from 1 |
| pixelCnt | output | PW (10 by default) | Pixel cycle within the current line, counted from 0 |
| activeLine | output | 1 | High on lines where video data is expected |

## Verification
In every frame the frame boundary coincides with several other events on one edge: the end of the last line, the start of the first-field sync pulse, the field flag returning to 0, and the resampling of the mode request. In progressive mode the line-number wrap also falls on that edge. The bench provokes this by changing modeSel partway through a frame in each direction. It then checks, at the first pixel after the boundary, the new mode's start line, the falling sync, the cleared field flag, and a line length and pulse length that belong to the new mode. The field-two start, where the field flag and the falling sync share an edge, is checked at the last pixel before that edge and at the first pixel after it.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  typedef enum logic {
    SCAN_INTERLACED  = 1'b0,
    SCAN_PROGRESSIVE = 1'b1
  } scanMode_t;

  // strobes from control to datapath, valid for the current pixel cycle
  typedef struct packed {
    logic lineEnd;     // last pixel of the line
    logic frameEnd;    // last pixel of the frame
    logic lineWrap;    // last pixel of the highest numbered line
    logic nextActive;  // line about to start carries video
    logic nextProg;    // mode of the frame that starts after frameEnd
  } stepStrobes_t;

endpackage

// File: rtl/ftg_ctrl.sv
module ftg_ctrl
  import ftg_pkg::*;
#(
  parameter int NTSC_PIX      = 858,
  parameter int PAL_PIX       = 864,
  parameter int NTSC_LINES    = 525,
  parameter int PAL_LINES     = 625,
  parameter int NTSC_F1_LINE  = 4,
  parameter int NTSC_F2_LINE  = 266,
  parameter int PAL_F1_LINE   = 1,
  parameter int PAL_F2_LINE   = 313,
  parameter int NTSC_VS_HALF  = 6,
  parameter int PAL_VS_HALF   = 5,
  parameter int NTSC_ACT1_LO  = 22,
  parameter int NTSC_ACT1_HI  = 261,
  parameter int NTSC_ACT2_LO  = 284,
  parameter int NTSC_ACT2_HI  = 522,
  parameter int PAL_ACT1_LO   = 23,
  parameter int PAL_ACT1_HI   = 309,
  parameter int PAL_ACT2_LO   = 335,
  parameter int PAL_ACT2_HI   = 622,
  parameter int PW            = 10,
  parameter int LW            = 10,
  parameter int VW            = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            modeSel,
  input  logic [PW-1:0]   pixelCnt,
  input  logic [LW-1:0]   lineNum,
  output stepStrobes_t    strb,
  output logic            fieldFlag,
  output logic            vsyncN
);

  // sync lengths in pixel cycles, from half-line counts
  localparam int N_VS_LEN = (NTSC_PIX * NTSC_VS_HALF) / 2;
  localparam int P_VS_LEN = (PAL_PIX * PAL_VS_HALF) / 2;

  // last line of a frame is the one before the first field's first line
  localparam int N_LAST_F = (NTSC_F1_LINE == 1) ? NTSC_LINES : NTSC_F1_LINE - 1;
  localparam int P_LAST_F = (PAL_F1_LINE == 1) ? PAL_LINES : PAL_F1_LINE - 1;

  localparam logic [PW-1:0] N_PIX_LAST  = PW'(NTSC_PIX - 1);
  localparam logic [PW-1:0] P_PIX_LAST  = PW'(PAL_PIX - 1);
  localparam logic [LW-1:0] N_FRAME_END = LW'(N_LAST_F);
  localparam logic [LW-1:0] P_FRAME_END = LW'(P_LAST_F);
  localparam logic [LW-1:0] N_TOP_LINE  = LW'(NTSC_LINES);
  localparam logic [LW-1:0] P_TOP_LINE  = LW'(PAL_LINES);
  localparam logic [LW-1:0] N_F2_PREV   = LW'(NTSC_F2_LINE - 1);
  localparam logic [LW-1:0] P_F2_PREV   = LW'(PAL_F2_LINE - 1);
  localparam logic [VW-1:0] N_VS_LOAD   = VW'(N_VS_LEN - 1);
  localparam logic [VW-1:0] P_VS_LOAD   = VW'(P_VS_LEN - 1);

  function automatic logic inWin(input logic [LW-1:0] ln, input int lo, input int hi);
    return (int'(ln) >= lo) && (int'(ln) <= hi);
  endfunction

  scanMode_t       curMode;
  scanMode_t       modeReq;
  logic            isProg;
  logic [PW-1:0]   pixLast;
  logic [LW-1:0]   frameLastLine;
  logic [LW-1:0]   topLine;
  logic [LW-1:0]   f2PrevLine;
  logic [LW-1:0]   lineAhead;
  logic [VW-1:0]   vsLoadCur;
  logic [VW-1:0]   vsLoadReq;
  logic [VW-1:0]   vsCnt;
  logic            winHit;
  logic            fieldTwoStart;

  assign modeReq = modeSel ? SCAN_PROGRESSIVE : SCAN_INTERLACED;
  assign isProg  = (curMode == SCAN_PROGRESSIVE);

  // per-mode limits for the frame in progress
  always_comb begin
    if (isProg) begin
      pixLast       = P_PIX_LAST;
      frameLastLine = P_FRAME_END;
      topLine       = P_TOP_LINE;
      f2PrevLine    = P_F2_PREV;
      vsLoadCur     = P_VS_LOAD;
    end else begin
      pixLast       = N_PIX_LAST;
      frameLastLine = N_FRAME_END;
      topLine       = N_TOP_LINE;
      f2PrevLine    = N_F2_PREV;
      vsLoadCur     = N_VS_LOAD;
    end
    vsLoadReq = modeSel ? P_VS_LOAD : N_VS_LOAD;
  end

  // active window of the line that follows the current one
  always_comb begin
    lineAhead = lineNum + LW'(1);
    if (isProg)
      winHit = inWin(lineAhead, PAL_ACT1_LO, PAL_ACT1_HI) ||
               inWin(lineAhead, PAL_ACT2_LO, PAL_ACT2_HI);
    else
      winHit = inWin(lineAhead, NTSC_ACT1_LO, NTSC_ACT1_HI) ||
               inWin(lineAhead, NTSC_ACT2_LO, NTSC_ACT2_HI);
  end

  always_comb begin
    strb.lineEnd    = (pixelCnt == pixLast);
    strb.frameEnd   = strb.lineEnd && (lineNum == frameLastLine);
    strb.lineWrap   = strb.lineEnd && (lineNum == topLine);
    strb.nextActive = winHit && !strb.frameEnd && !strb.lineWrap;
    strb.nextProg   = modeSel;
    fieldTwoStart   = strb.lineEnd && (lineNum == f2PrevLine);
  end

  // mode capture, field flag and sync pulse counter
  always_ff @(posedge clk) begin
    if (rst) begin
      curMode   <= modeReq;
      fieldFlag <= 1'b0;
      vsyncN    <= 1'b0;
      vsCnt     <= vsLoadReq;
    end else if (strb.frameEnd) begin
      curMode   <= modeReq;
      fieldFlag <= 1'b0;
      vsyncN    <= 1'b0;
      vsCnt     <= vsLoadReq;
    end else if (fieldTwoStart) begin
      fieldFlag <= 1'b1;
      vsyncN    <= 1'b0;
      vsCnt     <= vsLoadCur;
    end else if (!vsyncN) begin
      if (vsCnt == '0) vsyncN <= 1'b1;
      else             vsCnt  <= vsCnt - VW'(1);
    end
  end

endmodule

// File: rtl/ftg_datapath.sv
module ftg_datapath
  import ftg_pkg::*;
#(
  parameter int NTSC_F1_LINE = 4,
  parameter int PAL_F1_LINE  = 1,
  parameter int PW           = 10,
  parameter int LW           = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          modeSel,
  input  stepStrobes_t  strb,
  output logic [PW-1:0] pixelCnt,
  output logic [LW-1:0] lineNum,
  output logic          activeLine
);

  localparam logic [LW-1:0] N_START    = LW'(NTSC_F1_LINE);
  localparam logic [LW-1:0] P_START    = LW'(PAL_F1_LINE);
  localparam logic [LW-1:0] FIRST_LINE = LW'(1);

  logic [LW-1:0] lineNext;

  always_comb begin
    if (strb.frameEnd)      lineNext = strb.nextProg ? P_START : N_START;
    else if (strb.lineWrap) lineNext = FIRST_LINE;
    else                    lineNext = lineNum + FIRST_LINE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pixelCnt   <= '0;
      lineNum    <= modeSel ? P_START : N_START;
      activeLine <= 1'b0;
    end else if (strb.lineEnd) begin
      pixelCnt   <= '0;
      lineNum    <= lineNext;
      activeLine <= strb.nextActive;
    end else begin
      pixelCnt   <= pixelCnt + PW'(1);
    end
  end

endmodule

// File: rtl/field_timing_gen.sv
module field_timing_gen
  import ftg_pkg::*;
#(
  parameter int NTSC_PIX      = 858,
  parameter int PAL_PIX       = 864,
  parameter int NTSC_LINES    = 525,
  parameter int PAL_LINES     = 625,
  parameter int NTSC_F1_LINE  = 4,
  parameter int NTSC_F2_LINE  = 266,
  parameter int PAL_F1_LINE   = 1,
  parameter int PAL_F2_LINE   = 313,
  parameter int NTSC_VS_HALF  = 6,
  parameter int PAL_VS_HALF   = 5,
  parameter int NTSC_ACT1_LO  = 22,
  parameter int NTSC_ACT1_HI  = 261,
  parameter int NTSC_ACT2_LO  = 284,
  parameter int NTSC_ACT2_HI  = 522,
  parameter int PAL_ACT1_LO   = 23,
  parameter int PAL_ACT1_HI   = 309,
  parameter int PAL_ACT2_LO   = 335,
  parameter int PAL_ACT2_HI   = 622,
  localparam int MAX_PIX   = (PAL_PIX > NTSC_PIX) ? PAL_PIX : NTSC_PIX,
  localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
  localparam int N_VS      = (NTSC_PIX * NTSC_VS_HALF) / 2,
  localparam int P_VS      = (PAL_PIX * PAL_VS_HALF) / 2,
  localparam int PW        = $clog2(MAX_PIX),
  localparam int LW        = $clog2(MAX_LINES + 1),
  localparam int VW        = $clog2((P_VS > N_VS) ? P_VS : N_VS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          modeSel,
  output logic          vsyncN,
  output logic          fieldOut,
  output logic [LW-1:0] lineNum,
  output logic [PW-1:0] pixelCnt,
  output logic          activeLine
);

  stepStrobes_t strb;

  ftg_ctrl #(
    .NTSC_PIX(NTSC_PIX), .PAL_PIX(PAL_PIX),
    .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .NTSC_F1_LINE(NTSC_F1_LINE), .NTSC_F2_LINE(NTSC_F2_LINE),
    .PAL_F1_LINE(PAL_F1_LINE), .PAL_F2_LINE(PAL_F2_LINE),
    .NTSC_VS_HALF(NTSC_VS_HALF), .PAL_VS_HALF(PAL_VS_HALF),
    .NTSC_ACT1_LO(NTSC_ACT1_LO), .NTSC_ACT1_HI(NTSC_ACT1_HI),
    .NTSC_ACT2_LO(NTSC_ACT2_LO), .NTSC_ACT2_HI(NTSC_ACT2_HI),
    .PAL_ACT1_LO(PAL_ACT1_LO), .PAL_ACT1_HI(PAL_ACT1_HI),
    .PAL_ACT2_LO(PAL_ACT2_LO), .PAL_ACT2_HI(PAL_ACT2_HI),
    .PW(PW), .LW(LW), .VW(VW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .modeSel(modeSel),
    .pixelCnt(pixelCnt), .lineNum(lineNum),
    .strb(strb), .fieldFlag(fieldOut), .vsyncN(vsyncN)
  );

  ftg_datapath #(
    .NTSC_F1_LINE(NTSC_F1_LINE), .PAL_F1_LINE(PAL_F1_LINE),
    .PW(PW), .LW(LW)
  ) u_dp (
    .clk(clk), .rst(rst), .modeSel(modeSel), .strb(strb),
    .pixelCnt(pixelCnt), .lineNum(lineNum), .activeLine(activeLine)
  );

endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
  parameter int PW        = 10,
  parameter int LW        = 10,
  parameter int MAX_PIX   = 864,
  parameter int MAX_LINES = 625
) (
  input logic          clk,
  input logic          rst,
  input logic          vsyncN,
  input logic          fieldOut,
  input logic          activeLine,
  input logic [PW-1:0] pixelCnt,
  input logic [LW-1:0] lineNum
);

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    (pixelCnt != '0) |-> (pixelCnt == $past(pixelCnt) + PW'(1))); // R2
  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(pixelCnt) < MAX_PIX); // R2
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pixelCnt != '0) |-> $stable(lineNum)); // R2
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(lineNum) >= 1) && (int'(lineNum) <= MAX_LINES)); // R3
  AST_VSYNC_FALL_LINE_START: assert property (@(posedge clk) disable iff (rst)
    $fell(vsyncN) |-> (pixelCnt == '0)); // R4
  AST_FIELD_WITH_VSYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(fieldOut) |-> $fell(vsyncN)); // R6
  AST_NO_ACTIVE_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    !vsyncN |-> !activeLine); // R7
  AST_ACTIVE_LINE_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(activeLine) |-> (pixelCnt == '0)); // R10

endmodule

bind field_timing_gen ftg_checker #(
  .PW(PW), .LW(LW), .MAX_PIX(MAX_PIX), .MAX_LINES(MAX_LINES)
) u_chk (
  .clk(clk), .rst(rst), .vsyncN(vsyncN), .fieldOut(fieldOut),
  .activeLine(activeLine), .pixelCnt(pixelCnt), .lineNum(lineNum)
);

// File: tb/tb_field_timing_gen.sv
module tb_field_timing_gen;

  // shortened lines keep whole frames inside the run budget
  localparam int NPIX   = 22;
  localparam int PPIX   = 24;
  localparam int NLINES = 525;
  localparam int PLINES = 625;
  localparam int PW     = $clog2(PPIX);
  localparam int LW     = $clog2(PLINES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeSel = 1'b1;
  logic vsyncN, fieldOut, activeLine;
  logic [PW-1:0] pixelCnt;
  logic [LW-1:0] lineNum;

  always #5 clk = ~clk;

  field_timing_gen #(.NTSC_PIX(NPIX), .PAL_PIX(PPIX)) dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .vsyncN(vsyncN),
    .fieldOut(fieldOut), .lineNum(lineNum), .pixelCnt(pixelCnt),
    .activeLine(activeLine)
  );

  typedef struct packed {
    logic       prog;
    logic [1:0] frm;
    logic [9:0] ln;
    logic [9:0] px;
    logic       vs;
    logic       fld;
    logic       act;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd0, 10'd1,   10'd0,  1'b0, 1'b0, 1'b0},
    '{1'b1, 2'd0, 10'd3,   10'd11, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'd0, 10'd3,   10'd12, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd0, 10'd22,  10'd23, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd0, 10'd23,  10'd0,  1'b1, 1'b0, 1'b1},
    '{1'b1, 2'd0, 10'd309, 10'd23, 1'b1, 1'b0, 1'b1},
    '{1'b1, 2'd0, 10'd310, 10'd0,  1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd0, 10'd312, 10'd23, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'd0, 10'd313, 10'd0,  1'b0, 1'b1, 1'b0},
    '{1'b1, 2'd0, 10'd315, 10'd11, 1'b0, 1'b1, 1'b0},
    '{1'b1, 2'd0, 10'd315, 10'd12, 1'b1, 1'b1, 1'b0},
    '{1'b1, 2'd0, 10'd334, 10'd23, 1'b1, 1'b1, 1'b0},
    '{1'b1, 2'd0, 10'd335, 10'd0,  1'b1, 1'b1, 1'b1},
    '{1'b1, 2'd0, 10'd622, 10'd23, 1'b1, 1'b1, 1'b1},
    '{1'b1, 2'd0, 10'd623, 10'd0,  1'b1, 1'b1, 1'b0},
    '{1'b1, 2'd0, 10'd625, 10'd23, 1'b1, 1'b1, 1'b0},
    '{1'b1, 2'd1, 10'd1,   10'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd4,   10'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd6,   10'd21, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd7,   10'd0,  1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd21,  10'd21, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd22,  10'd0,  1'b1, 1'b0, 1'b1},
    '{1'b0, 2'd0, 10'd261, 10'd21, 1'b1, 1'b0, 1'b1},
    '{1'b0, 2'd0, 10'd262, 10'd0,  1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd265, 10'd21, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 10'd266, 10'd0,  1'b0, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd268, 10'd21, 1'b0, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd269, 10'd0,  1'b1, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd283, 10'd21, 1'b1, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd284, 10'd0,  1'b1, 1'b1, 1'b1},
    '{1'b0, 2'd0, 10'd522, 10'd21, 1'b1, 1'b1, 1'b1},
    '{1'b0, 2'd0, 10'd523, 10'd0,  1'b1, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd525, 10'd21, 1'b1, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd1,   10'd0,  1'b1, 1'b1, 1'b0},
    '{1'b0, 2'd0, 10'd3,   10'd21, 1'b1, 1'b1, 1'b0},
    '{1'b0, 2'd1, 10'd4,   10'd0,  1'b0, 1'b0, 1'b0}
  };

  int checks = 0;
  int fails  = 0;
  int curT   = 0;

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, curT);
    end
  endtask

  // leaves the bench at a falling edge with the reset state visible
  task automatic doReset(input logic prog);
    @(negedge clk);
    rst = 1'b1;
    modeSel = prog;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    curT = 0;
  endtask

  task automatic advance(input int t);
    while (curT < t) begin
      @(negedge clk);
      curT++;
    end
  endtask

  function automatic int posT(input logic prog, input int frm, input int ln, input int px);
    if (prog) return frm * PLINES * PPIX + (ln - 1) * PPIX + px;
    else      return frm * NLINES * NPIX + ((ln >= 4) ? ln - 4 : ln + 521) * NPIX + px;
  endfunction

  task automatic checkPos(input int ln, input int px, input string req);
    check(int'(lineNum), ln, req, "lineNum");
    check(int'(pixelCnt), px, req, "pixelCnt");
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual run still going after %0d cycles, expected completion", 120000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    // table walk: positions in both modes, tagged R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      if (i == 0) doReset(TBL[i].prog);
      else if (TBL[i].prog != TBL[i-1].prog) doReset(TBL[i].prog);
      advance(posT(TBL[i].prog, int'(TBL[i].frm), int'(TBL[i].ln), int'(TBL[i].px)));
      check(int'(lineNum), int'(TBL[i].ln), "R3", "lineNum");
      check(int'(pixelCnt), int'(TBL[i].px), "R2", "pixelCnt");
      check(int'(vsyncN), int'(TBL[i].vs), TBL[i].prog ? "R4" : "R5", "vsyncN");
      check(int'(fieldOut), int'(TBL[i].fld), "R6", "fieldOut");
      check(int'(activeLine), int'(TBL[i].act), TBL[i].prog ? "R7" : "R8", "activeLine");
    end

    // R1 reset state in both modes
    doReset(1'b1);
    checkPos(1, 0, "R1");
    check(int'(vsyncN), 0, "R1", "vsyncN");
    check(int'(fieldOut), 0, "R1", "fieldOut");
    check(int'(activeLine), 0, "R1", "activeLine");
    doReset(1'b0);
    checkPos(4, 0, "R1");
    check(int'(vsyncN), 0, "R1", "vsyncN");
    check(int'(activeLine), 0, "R1", "activeLine");

    // R10 enable changes exactly at a line start
    advance(posT(1'b0, 0, 21, 21));
    check(int'(activeLine), 0, "R10", "activeLine last pixel before window");
    advance(curT + 1);
    checkPos(22, 0, "R10");
    check(int'(activeLine), 1, "R10", "activeLine first pixel of window");

    // R9 progressive to interlaced, request made mid-frame
    doReset(1'b1);
    advance(100);
    modeSel = 1'b0;
    advance(posT(1'b1, 0, 5, 23));
    checkPos(5, 23, "R9");
    advance(posT(1'b1, 0, 400, 0));
    checkPos(400, 0, "R9");
    advance(PLINES * PPIX - 1);
    checkPos(625, 23, "R9");
    advance(curT + 1);
    checkPos(4, 0, "R9");
    check(int'(vsyncN), 0, "R9", "vsyncN at new frame");
    check(int'(fieldOut), 0, "R9", "fieldOut at new frame");
    advance(curT + NPIX);
    checkPos(5, 0, "R9");

    // R9 interlaced to progressive
    doReset(1'b0);
    advance(50);
    modeSel = 1'b1;
    base = NLINES * NPIX;
    advance(base - 1);
    checkPos(3, 21, "R9");
    check(int'(fieldOut), 1, "R9", "fieldOut before boundary");
    advance(base);
    checkPos(1, 0, "R9");
    check(int'(vsyncN), 0, "R9", "vsyncN at new frame");
    check(int'(fieldOut), 0, "R9", "fieldOut at new frame");
    advance(base + PPIX);
    checkPos(2, 0, "R9");
    advance(base + 59);
    check(int'(vsyncN), 0, "R4", "vsyncN last low cycle after switch");
    advance(base + 60);
    check(int'(vsyncN), 1, "R4", "vsyncN rise after switch");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule